// File: doc/BRIEF.md
# Path-correlated two-level branch direction predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent resolved branch outcomes. That record picks one of several banks of saturating counters. A few low-order bits of the branch address then pick one counter inside that bank, and the counter's upper half means "taken". Because of this, the same branch address can be predicted differently depending on the path that led to it.

The fetch side presents an address and reads the prediction back combinationally in the same cycle. When a branch resolves, the back end drives the resolved address, the real direction and a strobe. On the next clock edge, the predictor nudges the chosen counter towards that direction and then shifts the direction into the history. No address tag is stored, so branches that share index bits share counters. Sizing is set by three parameters: history length, counter width and index width. With zero history bits the block reduces to a plain table of counters.

Top module: `corr_bpred`

## Requirements
- R1: While reset is asserted and immediately after it is released, every counter holds the weakly-not-taken value 2^(CTR_W-1)-1 (binary 01 for 2-bit counters), the history is zero, and every lookup predicts not-taken.
- R2: The prediction is taken exactly when the selected counter is in the upper half of its range, i.e. its value is at least 2^(CTR_W-1).
- R3: The counter entry is chosen by address bits [IDX_LSB+IDX_W-1:IDX_LSB]; all other address bits have no effect, so addresses that agree in those bits share an entry (no tag check).
- R4: The bank is chosen by the history value read as an unsigned number, with bit 0 holding the most recent outcome. The same index can therefore predict differently under different histories.
- R5: A valid update moves the counter selected by the resolved address and by the history as it stood before the update. The counter is incremented on taken and decremented on not-taken, saturating at 0 and 2^CTR_W-1.
- R6: Each valid update shifts the real direction into history bit 0 and drops the oldest bit. Without a valid strobe, the history holds its value.
- R7: A valid update writes exactly one counter in exactly one bank; when the strobe is low, no counter is written and the inputs of the update port have no effect.
- R8: A lookup is combinational. An update presented in the same cycle becomes visible only after the next rising clock edge.
- R9: With 2-bit counters, a counter saturated in one direction needs two consecutive opposite outcomes before its prediction flips.
- R10: With HIST_W = 0 the block is a single table indexed by address alone, and its predictions are unaffected by earlier outcomes at other indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Strobe: a resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch, 1 = taken |

## Verification
Every cycle, the assertions check several properties. Bank write enables stay one-hot on an update and all low otherwise. The history shifts in the real outcome on every strobe and holds without one. It is zero right after reset. The prediction stays constant while neither the address nor the state changes. The counter arithmetic itself is only visible through the scenarios in the bench. These cover saturation at both ends, the two-step hysteresis, the dependence on the pre-update history, aliasing through ignored address bits, the same-cycle lookup seeing old state, and the history-free variant. Each scenario is compared against a counter-by-counter model over every index.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

  // Counters up to 8 bits wide are carried in a byte for the helpers below.
  localparam int unsigned CTR_MAX_W = 8;

  // Value a counter takes after reset: the weakest not-taken state.
  function automatic logic [CTR_MAX_W-1:0] ctr_reset_val(input int unsigned w);
    return CTR_MAX_W'((1 << (w - 1)) - 1);
  endfunction

  // Top of the counter range.
  function automatic logic [CTR_MAX_W-1:0] ctr_top(input int unsigned w);
    return CTR_MAX_W'((1 << w) - 1);
  endfunction

  // Saturating step towards the observed direction.
  function automatic logic [CTR_MAX_W-1:0] ctr_step(input int unsigned w,
                                                     input logic [CTR_MAX_W-1:0] c,
                                                     input logic taken);
    logic [CTR_MAX_W-1:0] r;
    if (taken) r = (c == ctr_top(w)) ? c : c + 1'b1;
    else       r = (c == '0)         ? c : c - 1'b1;
    return r;
  endfunction

  // Upper half of the range predicts taken.
  function automatic logic ctr_is_taken(input int unsigned w,
                                        input logic [CTR_MAX_W-1:0] c);
    return c >= CTR_MAX_W'(1 << (w - 1));
  endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int unsigned HIST_W = 2,
  parameter int unsigned HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HW_EFF-1:0] hist_q
);

  generate
    if (HIST_W == 0) begin : g_none
      // No path history: a single bank is always selected.
      assign hist_q = '0;
    end else begin : g_shift
      logic [HW_EFF:0]   widened;
      logic [HW_EFF-1:0] hist_r;

      // Newest outcome lands in bit 0, the oldest falls off the top.
      assign widened = {hist_r, bit_in};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_r <= '0;
        else if (shift_en) hist_r <= widened[HW_EFF-1:0];
      end

      assign hist_q = hist_r;
    end
  endgenerate

endmodule

// File: rtl/bp_bank_dec.sv
module bp_bank_dec #(
  parameter int unsigned NB    = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NB-1:0]    we
);

  generate
    for (genvar b = 0; b < NB; b++) begin : g_we
      assign we[b] = en && (sel == SEL_W'(b));
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
  import corr_bpred_pkg::*;
#(
  parameter int unsigned CTR_W = 2,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr
);

  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(ctr_reset_val(CTR_W));

  logic [CTR_W-1:0] ctr_mem [DEPTH];
  logic [CTR_W-1:0] wr_old;
  logic [CTR_W-1:0] wr_new;

  // Read-modify-write on the update side.
  assign wr_old = ctr_mem[wr_idx];
  assign wr_new = CTR_W'(ctr_step(CTR_W, CTR_MAX_W'(wr_old), wr_taken));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= RST_VAL;
    end else if (we) begin
      ctr_mem[wr_idx] <= wr_new;
    end
  end

  // Lookup side is purely combinational.
  assign rd_ctr = ctr_mem[rd_idx];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import corr_bpred_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned HIST_W  = 2,
  parameter int unsigned CTR_W   = 2,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned IDX_LSB = 2,
  localparam int unsigned HW_EFF = (HIST_W > 0) ? HIST_W : 1,
  localparam int unsigned NB     = 1 << HIST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  // Named internal events, also used by the bound checker.
  logic [HW_EFF-1:0] hist_q;
  logic [HW_EFF-1:0] lk_bank;
  logic [HW_EFF-1:0] upd_bank;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [NB-1:0]     bank_we;
  logic [CTR_W-1:0]  bank_rd [NB];
  logic [CTR_W-1:0]  lk_ctr;
  logic              unused_pc_bits;

  assign lk_idx   = lk_pc[IDX_LSB +: IDX_W];
  assign upd_idx  = up_pc[IDX_LSB +: IDX_W];
  assign lk_bank  = hist_q;
  assign upd_bank = hist_q;   // history before this update picks the bank
  assign unused_pc_bits = ^{lk_pc, up_pc};

  bp_hist_reg #(.HIST_W(HIST_W), .HW_EFF(HW_EFF)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist_q   (hist_q)
  );

  bp_bank_dec #(.NB(NB), .SEL_W(HW_EFF)) u_dec (
    .en  (up_valid),
    .sel (upd_bank),
    .we  (bank_we)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      bp_ctr_bank #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bank_we[b]),
        .wr_idx   (upd_idx),
        .wr_taken (up_taken),
        .rd_idx   (lk_idx),
        .rd_ctr   (bank_rd[b])
      );
    end
  endgenerate

  always_comb begin
    lk_ctr = bank_rd[0];
    for (int b = 0; b < NB; b++) begin
      if (lk_bank == HW_EFF'(b)) lk_ctr = bank_rd[b];
    end
  end

  assign lk_taken = ctr_is_taken(CTR_W, CTR_MAX_W'(lk_ctr));

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned HW_EFF = 2,
  parameter int unsigned NB     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_taken,
  input logic [HW_EFF-1:0] hist_q,
  input logic [NB-1:0]     bank_we
);

  logic [HW_EFF:0]   hist_cat;
  logic [HW_EFF-1:0] hist_expect;

  assign hist_cat    = {hist_q, up_taken};
  assign hist_expect = (HIST_W == 0) ? '0 : hist_cat[HW_EFF-1:0];

  // R7
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R7
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |-> (bank_we == '0));

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> ($countones(bank_we) == 1));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (hist_q == $past(hist_expect)));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist_q));

  // R1
  hist_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hist_q == '0));

  // R8
  pred_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

bind corr_bpred corr_bpred_chk #(
  .PC_W(PC_W), .HIST_W(HIST_W), .HW_EFF(HW_EFF), .NB(NB)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .lk_pc    (lk_pc),
  .lk_taken (lk_taken),
  .hist_q   (hist_q),
  .bank_we  (bank_we)
);

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;

  localparam int M   = 2;
  localparam int P   = 3;
  localparam int LSB = 2;
  localparam int NE  = 1 << P;
  localparam int NBK = 1 << M;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        lk_a;
  logic        lk_b;

  int n_chk = 0;
  int n_fail = 0;

  int ctr_a [NBK][NE];
  int ctr_b [NE];
  int hist;

  always #10 clk = ~clk;

  corr_bpred #(.PC_W(32), .HIST_W(M), .CTR_W(2), .IDX_W(P), .IDX_LSB(LSB)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_a),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  corr_bpred #(.PC_W(32), .HIST_W(0), .CTR_W(2), .IDX_W(P), .IDX_LSB(LSB)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_b),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> LSB) & (NE - 1));
  endfunction

  function automatic int sat(input int c, input logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic exp_a(input logic [31:0] pc);
    return ctr_a[hist][idx_of(pc)] >= 2;
  endfunction

  function automatic logic exp_b(input logic [31:0] pc);
    return ctr_b[idx_of(pc)] >= 2;
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NBK; b++)
      for (int i = 0; i < NE; i++) ctr_a[b][i] = 1;
    for (int i = 0; i < NE; i++) ctr_b[i] = 1;
    hist = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Lookup every index once, with random bits outside the index field (R3).
  task automatic sweep(input string req);
    @(negedge clk);
    for (int i = 0; i < NE; i++) begin
      logic [31:0] pc;
      pc = ($urandom() & ~32'(((NE - 1) << LSB))) | 32'(i << LSB);
      lk_pc = pc;
      #1;
      check(lk_a, exp_a(pc), req, "history table lookup");
      check(lk_b, exp_b(pc), req, "flat table lookup");
    end
  endtask

  // One update; same-cycle lookup must still see the old state (R8).
  task automatic upd(input logic [31:0] pc, input logic t);
    int i;
    @(negedge clk);
    up_valid = 1'b1;
    up_pc = pc;
    up_taken = t;
    lk_pc = pc;
    #1;
    check(lk_a, exp_a(pc), "R8", "same-cycle lookup, history table");
    check(lk_b, exp_b(pc), "R8", "same-cycle lookup, flat table");
    @(posedge clk);
    i = idx_of(pc);
    ctr_a[hist][i] = sat(ctr_a[hist][i], t);
    ctr_b[i] = sat(ctr_b[i], t);
    hist = ((hist << 1) | int'(t)) & (NBK - 1);
    #1;
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc);
    @(negedge clk);
    lk_pc = pc;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R1: everything weakly not-taken after reset
    sweep("R1");
    look(32'h0000_0010);
    check(lk_a, 1'b0, "R1", "reset prediction");

    // R9, R5, R2 on the flat table: 01 -> 10 -> 11 -> 11 -> 10 -> 01
    upd(32'h0000_0004, 1'b1); look(32'h0000_0004); check(lk_b, 1'b1, "R2", "one taken from weak NT");
    upd(32'h0000_0004, 1'b1);
    upd(32'h0000_0004, 1'b1); look(32'h0000_0004); check(lk_b, 1'b1, "R5", "saturated high");
    upd(32'h0000_0004, 1'b0); look(32'h0000_0004); check(lk_b, 1'b1, "R9", "first opposite keeps taken");
    upd(32'h0000_0004, 1'b0); look(32'h0000_0004); check(lk_b, 1'b0, "R9", "second opposite flips");
    upd(32'h0000_0004, 1'b0);
    upd(32'h0000_0004, 1'b0);
    upd(32'h0000_0004, 1'b1); look(32'h0000_0004); check(lk_b, 1'b0, "R5", "saturated low needs two");
    sweep("R5");

    // R4: one taken in history 0 trains bank 0 only; lookup then uses bank 1
    do_reset();
    upd(32'h0000_0004, 1'b1);
    look(32'h0000_0004);
    check(lk_a, 1'b0, "R4", "new history selects untrained bank");
    check(lk_b, 1'b1, "R10", "flat table ignores history");
    look(32'hABC0_0007);
    check(lk_a, 1'b0, "R3", "alias with other high/low bits");
    check(lk_b, 1'b1, "R3", "alias on flat table");
    sweep("R4");

    // R6, R7: idle cycles with garbage on the update port change nothing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      up_valid = 1'b0;
      up_pc = $urandom();
      up_taken = 1'($urandom());
    end
    sweep("R7");

    // Mixed stream with checks over every index
    for (int k = 0; k < 400; k++) begin
      logic [31:0] pc;
      pc = $urandom();
      upd(pc, (($urandom() % 4) != 0) ^ (idx_of(pc) == 3));
      if ((k % 10) == 9) sweep("R6");
    end
    sweep("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule